// File: doc/BRIEF.md
# Burst Permission and Error Accumulation Controller

This block sits between a peripheral's FIFO side and a system-bus master port. Every transaction moves four words, handled as two halves of two words. When a transaction is accepted, the block decides whether it goes out as one 4-beat incrementing burst or as four separate single beats. The decision depends on which of eight address regions the top three address bits select, and on global read-burst and write-burst enables. A 32-bit control register holds all of these controls.

For a write burst, the block pulls the first two words from the FIFO and then gives the FIFO side an early "no error" completion for that half, before any bus activity. It then pulls the second two words and writes all four on the bus. An error on the first half's bus beats is handled by the accumulate control. With the control clear, the error is dropped. With the control set, the error is merged into the completion for the second half. For single-beat transfers and for reads, each half's completion reports the errors of its own two beats.

The bus port carries one beat at a time. A beat's address phase is held until the slave signals ready, and the next address phase starts only after that.

Top module: `bpc_ctrl`

## Requirements
- R1: After reset the control register reads 0, the block is idle (`req_ready`=1), and no bus beat, FIFO pop or completion is active.
- R2: The control register uses MSB-first numbering and reads back as follows. Bit 0 (`[31]`) to bit 3 (`[28]`) are the enables for regions 0 to 3. Bits 4 and 5 (`[27:26]`) always read 0. Bits 6 and 7 (`[25:24]`) are the enables for regions 6 and 7. Bit 8 (`[23]`) is the read-burst enable, bit 9 (`[22]`) the write-burst enable and bit 10 (`[21]`) the accumulate control. Every other bit reads 0, so writing all ones reads back 0xF3E00000.
- R3: A read goes out as a burst (`bus_burst`=1 on all four beats) only when the read-burst enable and the enable of region `req_addr[31:29]` are both set. Regions 4 and 5 never burst. Otherwise all beats have `bus_burst`=0.
- R4: A write goes out as a burst only when the write-burst enable and the region's enable are both set. Otherwise it goes out as single beats.
- R5: Each transaction issues four beats at addresses base, base+4, base+8 and base+12. `bus_seq` is 0 on the first beat of a burst and 1 on its later beats, and 0 on every single beat. While `bus_ready` is low, the address and direction are held.
- R6: For a write burst, the first completion (`resp_err`=0) comes after exactly two FIFO pops and before any bus beat. The second completion comes after all four beats.
- R7: With the accumulate control at 0, a bus error on beat 0 or 1 of a write burst shows in neither completion. An error on beat 2 or 3 shows in the second completion.
- R8: With the accumulate control at 1, a bus error on beat 0 or 1 of a write burst makes the second completion report an error, even when beats 2 and 3 complete without error.
- R9: A first-half error held for merging is cleared once the second completion is delivered, so the next error-free write burst completes with `resp_err`=0.
- R10: The burst decision is fixed when the request is accepted. A control-register write during a transaction changes only later transactions.
- R11: For single-beat writes and for reads, there is one completion after each half's two beats. Its `resp_err` is the OR of the errors of those two beats.
- R12: Write beat i carries the i-th word popped from the FIFO for that transaction. Pops never share a cycle with a bus beat.
- R13: On each completed read beat, `rd_valid` pulses with `rd_data` equal to that beat's `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| req_valid | input | 1 | FIFO side requests a 4-word transaction |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write to bus, 0 = read from bus |
| req_addr | input | 32 | Base byte address of the transaction |
| wd_pop | output | 1 | Pop one write word from the FIFO |
| wd_data | input | 32 | Write word at the FIFO head |
| rd_valid | output | 1 | Read word available |
| rd_data | output | 32 | Read word |
| resp_valid | output | 1 | Completion for one half |
| resp_err | output | 1 | Completion carries an error |
| bus_valid | output | 1 | Bus address phase active |
| bus_addr | output | 32 | Bus beat address |
| bus_write | output | 1 | Bus beat direction |
| bus_burst | output | 1 | Beat belongs to a 4-beat incrementing burst |
| bus_seq | output | 1 | Beat continues a burst |
| bus_wdata | output | 32 | Bus write data |
| bus_ready | input | 1 | Slave completes the beat |
| bus_err | input | 1 | Slave reports an error for the beat |
| bus_rdata | input | 32 | Slave read data |

## Verification
The burst decision is tried across a grid of register settings and targets: each global enable on its own, the region enable with and without its global enable, and the unimplemented regions 4 and 5 with everything on. This separates a gate that ignores the region from one that ignores direction. Error masks on one beat at a time, in the first half and then in the second, separate dropped errors from merged errors from per-half errors. A follow-up clean burst shows whether a merged error leaks into the next transaction. Two further cases use a slave that stalls every other cycle: one checks address hold, and one changes the register mid-transaction, which separates a latched decision from a live one.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_POP   = 3'd1,
        ST_EARLY = 3'd2,
        ST_BEAT  = 3'd3,
        ST_RESP  = 3'd4
    } bpc_state_e;

    typedef struct packed {
        logic [7:0] region_en;
        logic       rd_en;
        logic       wr_en;
        logic       acc_en;
    } bpc_cfg_t;

endpackage

// File: rtl/bpc_cfg_reg.sv
module bpc_cfg_reg
    import bpc_pkg::*;
#(
    parameter int          NREGION     = 8,
    parameter logic [7:0]  REGION_IMPL = 8'b1100_1111
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output bpc_cfg_t    cfg
);
    localparam int RD_POS  = 31 - NREGION;
    localparam int WR_POS  = RD_POS - 1;
    localparam int ACC_POS = RD_POS - 2;

    bpc_cfg_t   cfg_d, cfg_q;
    logic [7:0] wr_region;

    for (genvar i = 0; i < 8; i++) begin : g_region
        if (i < NREGION && REGION_IMPL[i]) begin : g_impl
            assign wr_region[i] = wdata[31-i];
        end else begin : g_absent
            assign wr_region[i] = 1'b0;
        end
    end

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.region_en = wr_region;
            cfg_d.rd_en     = wdata[RD_POS];
            cfg_d.wr_en     = wdata[WR_POS];
            cfg_d.acc_en    = wdata[ACC_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGION; i++) rdata[31-i] = cfg_q.region_en[i];
        rdata[RD_POS]  = cfg_q.rd_en;
        rdata[WR_POS]  = cfg_q.wr_en;
        rdata[ACC_POS] = cfg_q.acc_en;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bpc_burst_gate.sv
module bpc_burst_gate
    import bpc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  bpc_cfg_t          cfg,
    output logic              burst_ok
);
    logic [REGION_BITS-1:0] region;
    logic                   dir_en;

    always_comb begin
        region   = addr[ADDR_W-1 -: REGION_BITS];
        dir_en   = write ? cfg.wr_en : cfg.rd_en;
        burst_ok = dir_en & cfg.region_en[region];
    end
endmodule

// File: rtl/bpc_err_merge.sv
module bpc_err_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic beat_done,
    input  logic beat_err,
    input  logic first_half,
    input  logic resp_fire,
    input  logic resp_last,
    input  logic merge_en,
    input  logic acc_en,
    output logic resp_err
);
    typedef struct packed {
        logic first_err;
        logic half_err;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) st_d = '0;
        if (beat_done && beat_err) begin
            if (first_half) st_d.first_err = 1'b1;
            else            st_d.half_err  = 1'b1;
        end
        if (resp_fire) begin
            st_d.half_err = 1'b0;
            if (resp_last) st_d.first_err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_err = st_q.half_err | (merge_en & acc_en & st_q.first_err);
endmodule

// File: rtl/bpc_seq.sv
module bpc_seq
    import bpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              burst_ok,
    input  logic              acc_en,
    output logic              wd_pop,
    input  logic [DATA_W-1:0] wd_data,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_burst,
    output logic              bus_seq,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    output logic              resp_valid,
    output logic              resp_early,
    output logic              start,
    output logic              beat_done,
    output logic              first_half,
    output logic              resp_last,
    output logic              merge_en,
    output logic              acc_q_o
);
    localparam int HALF    = BEATS / 2;
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int BYTE_SH = $clog2(DATA_W / 8);
    localparam logic [BEAT_W-1:0] HALF_END = BEAT_W'(HALF - 1);
    localparam logic [BEAT_W-1:0] LAST     = BEAT_W'(BEATS - 1);

    typedef struct packed {
        bpc_state_e                    state;
        logic [BEAT_W-1:0]             beat;
        logic [BEAT_W-1:0]             pop;
        logic [ADDR_W-1:0]             addr;
        logic                          write;
        logic                          burst;
        logic                          acc;
        logic [BEATS-1:0][DATA_W-1:0]  wbuf;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       half_end;

    always_comb begin
        s_d        = s_q;
        req_ready  = 1'b0;
        wd_pop     = 1'b0;
        bus_valid  = 1'b0;
        resp_valid = 1'b0;
        resp_early = 1'b0;
        start      = 1'b0;
        beat_done  = 1'b0;
        half_end   = (s_q.beat == HALF_END) || (s_q.beat == LAST);

        case (s_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    start   = 1'b1;
                    s_d.addr  = req_addr;
                    s_d.write = req_write;
                    s_d.burst = burst_ok;
                    s_d.acc   = acc_en;
                    s_d.beat  = '0;
                    s_d.pop   = '0;
                    s_d.state = req_write ? ST_POP : ST_BEAT;
                end
            end
            ST_POP: begin
                wd_pop = 1'b1;
                s_d.wbuf[s_q.pop] = wd_data;
                s_d.pop = s_q.pop + 1'b1;
                if (s_q.pop == LAST)
                    s_d.state = ST_BEAT;
                else if (s_q.pop == HALF_END)
                    s_d.state = s_q.burst ? ST_EARLY : ST_BEAT;
            end
            ST_EARLY: begin
                resp_valid = 1'b1;
                resp_early = 1'b1;
                s_d.state  = ST_POP;
            end
            ST_BEAT: begin
                bus_valid = 1'b1;
                if (bus_ready) begin
                    beat_done = 1'b1;
                    s_d.beat  = s_q.beat + 1'b1;
                    if (half_end) begin
                        if (s_q.burst && s_q.write && s_q.beat == HALF_END)
                            s_d.state = ST_BEAT;
                        else
                            s_d.state = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                if (s_q.beat == '0)          s_d.state = ST_IDLE;
                else if (s_q.write)          s_d.state = ST_POP;
                else                         s_d.state = ST_BEAT;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_addr   = s_q.addr + (ADDR_W'(s_q.beat) << BYTE_SH);
    assign bus_write  = s_q.write;
    assign bus_burst  = s_q.burst;
    assign bus_seq    = s_q.burst && (s_q.beat != '0);
    assign bus_wdata  = s_q.wbuf[s_q.beat];
    assign first_half = s_q.burst && s_q.write && (s_q.beat <= HALF_END);
    assign resp_last  = (s_q.beat == '0);
    assign merge_en   = s_q.burst && s_q.write;
    assign acc_q_o    = s_q.acc;
endmodule

// File: rtl/bpc_ctrl.sv
module bpc_ctrl
    import bpc_pkg::*;
#(
    parameter int         ADDR_W      = 32,
    parameter int         DATA_W      = 32,
    parameter int         BEATS       = 4,
    parameter int         REGION_BITS = 3,
    parameter logic [7:0] REGION_IMPL = 8'b1100_1111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              wd_pop,
    input  logic [DATA_W-1:0] wd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              resp_valid,
    output logic              resp_err,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_burst,
    output logic              bus_seq,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int NREGION = 1 << REGION_BITS;

    bpc_cfg_t cfg;
    logic     burst_ok;
    logic     resp_early, start, beat_done, first_half, resp_last, merge_en, acc_q;
    logic     merged_err;

    bpc_cfg_reg #(.NREGION(NREGION), .REGION_IMPL(REGION_IMPL)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .cfg(cfg)
    );

    bpc_burst_gate #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_gate (
        .addr(req_addr), .write(req_write), .cfg(cfg), .burst_ok(burst_ok)
    );

    bpc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .burst_ok(burst_ok), .acc_en(cfg.acc_en),
        .wd_pop(wd_pop), .wd_data(wd_data),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_burst(bus_burst), .bus_seq(bus_seq), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .resp_valid(resp_valid), .resp_early(resp_early),
        .start(start), .beat_done(beat_done), .first_half(first_half),
        .resp_last(resp_last), .merge_en(merge_en), .acc_q_o(acc_q)
    );

    bpc_err_merge u_err (
        .clk(clk), .rst_n(rst_n), .start(start),
        .beat_done(beat_done), .beat_err(bus_err), .first_half(first_half),
        .resp_fire(resp_valid && !resp_early), .resp_last(resp_last),
        .merge_en(merge_en), .acc_en(acc_q), .resp_err(merged_err)
    );

    assign resp_err = resp_early ? 1'b0 : merged_err;
    assign rd_valid = bus_valid && bus_ready && !bus_write;
    assign rd_data  = bus_rdata;
endmodule

// File: rtl/bpc_ctrl_chk.sv
module bpc_ctrl_chk #(
    parameter int         ADDR_W      = 32,
    parameter int         REGION_BITS = 3,
    parameter logic [7:0] REGION_IMPL = 8'b1100_1111
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              wd_pop,
    input logic              resp_valid,
    input logic              rd_valid,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic              bus_burst,
    input logic              bus_seq,
    input logic [ADDR_W-1:0] bus_addr
);
    logic [REGION_BITS-1:0] bus_region;
    assign bus_region = bus_addr[ADDR_W-1 -: REGION_BITS];

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !wd_pop && !resp_valid));

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

    assert_seq_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_seq) |-> bus_burst);

    assert_region_impl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_burst) |-> REGION_IMPL[bus_region]);

    assert_pop_off_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_pop && bus_valid));

    assert_resp_off_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !bus_valid);

    assert_rd_on_read_beat_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (bus_valid && bus_ready && !bus_write));
endmodule

bind bpc_ctrl bpc_ctrl_chk #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .REGION_IMPL(REGION_IMPL)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wd_pop(wd_pop),
    .resp_valid(resp_valid), .rd_valid(rd_valid), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_burst(bus_burst),
    .bus_seq(bus_seq), .bus_addr(bus_addr)
);

// File: tb/bpc_ctrl_bench.sv
module bpc_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        wd_pop;
    logic [31:0] wd_data;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        resp_valid, resp_err;
    logic        bus_valid, bus_write, bus_burst, bus_seq;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ready, bus_err;

    int nchk = 0;
    int nerr = 0;

    logic       clr_log = 1'b0;
    logic       slow = 1'b0;
    logic [3:0] err_mask = '0;
    logic       wait_tog = 1'b0;
    int beat_n = 0, resp_n = 0, pop_n = 0, rd_n = 0;
    logic [31:0] lg_addr [8];
    logic [31:0] lg_wdata [8];
    logic        lg_burst [8];
    logic        lg_seq [8];
    logic        lg_rerr [8];
    int          lg_rbeat [8];
    int          lg_rpop [8];
    logic [31:0] lg_rd [8];

    always #2 clk = ~clk;

    bpc_ctrl u_bpc_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .wd_pop(wd_pop),
        .wd_data(wd_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .resp_valid(resp_valid), .resp_err(resp_err), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_burst(bus_burst),
        .bus_seq(bus_seq), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    assign wd_data   = 32'hD000_0000 + 32'(pop_n);
    assign bus_ready = bus_valid && (!slow || wait_tog);
    assign bus_err   = bus_valid && beat_n < 4 && err_mask[beat_n[1:0]];
    assign bus_rdata = bus_addr ^ 32'h5A5A_0000;

    always @(posedge clk) begin
        if (clr_log) begin
            beat_n = 0; resp_n = 0; pop_n = 0; rd_n = 0; wait_tog = 1'b0;
        end else begin
            if (bus_valid) wait_tog = ~wait_tog;
            if (resp_valid && resp_n < 8) begin
                lg_rerr[resp_n] = resp_err; lg_rbeat[resp_n] = beat_n;
                lg_rpop[resp_n] = pop_n; resp_n++;
            end
            if (rd_valid && rd_n < 8) begin lg_rd[rd_n] = rd_data; rd_n++; end
            if (wd_pop) pop_n++;
            if (bus_valid && bus_ready && beat_n < 8) begin
                lg_addr[beat_n] = bus_addr; lg_wdata[beat_n] = bus_wdata;
                lg_burst[beat_n] = bus_burst; lg_seq[beat_n] = bus_seq;
                beat_n++;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic start_txn(input logic wr, input logic [31:0] a, input logic [3:0] m);
        @(negedge clk); clr_log = 1'b1; err_mask = m;
        @(negedge clk); clr_log = 1'b0;
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic wait_txn();
        for (int i = 0; i < 200 && resp_n < 2; i++) @(negedge clk);
        @(negedge clk);
        chk("txn completes with two responses", 32'(resp_n), 32'd2);
    endtask

    task automatic run_txn(input logic wr, input logic [31:0] a, input logic [3:0] m);
        start_txn(wr, a, m);
        wait_txn();
    endtask

    task automatic chk_beats(input string tag, input logic [31:0] a, input logic bst);
        chk({tag, " beat count"}, 32'(beat_n), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk({tag, " R5 address"}, lg_addr[i], a + 32'(4 * i));
            chk({tag, " burst flag"}, 32'(lg_burst[i]), 32'(bst));
            chk({tag, " R5 seq flag"}, 32'(lg_seq[i]), 32'(bst && i != 0));
        end
    endtask

    task automatic t_reset();
        chk("R1 cfg after reset", cfg_rdata, 32'h0);
        chk("R1 idle after reset", 32'(req_ready), 32'd1);
        chk("R1 no beat after reset", 32'(bus_valid), 32'd0);
        chk("R1 no response after reset", 32'(resp_valid), 32'd0);
    endtask

    task automatic t_cfg_layout();
        cfg_write(32'hFFFF_FFFF);
        chk("R2 all-ones readback", cfg_rdata, 32'hF3E0_0000);
        cfg_write(32'h0C1F_FFFF);
        chk("R2 unused bits read zero", cfg_rdata, 32'h0);
        cfg_write(32'h0);
    endtask

    task automatic t_read_modes();
        run_txn(1'b0, 32'h0000_0100, 4'b0000);
        chk_beats("R3 reset-state read single", 32'h0000_0100, 1'b0);
        for (int i = 0; i < 4; i++)
            chk("R13 read data", lg_rd[i], (32'h0000_0100 + 32'(4 * i)) ^ 32'h5A5A_0000);
        cfg_write(32'h8080_0000);
        run_txn(1'b0, 32'h0000_0100, 4'b0000);
        chk_beats("R3 region0 read burst", 32'h0000_0100, 1'b1);
        cfg_write(32'h8040_0000);
        run_txn(1'b0, 32'h0000_0100, 4'b0000);
        chk_beats("R3 read with only write enable", 32'h0000_0100, 1'b0);
        cfg_write(32'hFFFF_FFFF);
        run_txn(1'b0, 32'h8000_0010, 4'b0000);
        chk_beats("R3 region4 never bursts", 32'h8000_0010, 1'b0);
        run_txn(1'b1, 32'hA000_0010, 4'b0000);
        chk_beats("R4 region5 write never bursts", 32'hA000_0010, 1'b0);
    endtask

    task automatic t_write_modes();
        cfg_write(32'h0280_0000);
        run_txn(1'b1, 32'hC000_0040, 4'b0000);
        chk_beats("R4 write with only read enable", 32'hC000_0040, 1'b0);
        cfg_write(32'h0240_0000);
        run_txn(1'b1, 32'hC000_0040, 4'b0000);
        chk_beats("R4 region6 write burst", 32'hC000_0040, 1'b1);
        for (int i = 0; i < 4; i++)
            chk("R12 write data order", lg_wdata[i], 32'hD000_0000 + 32'(i));
        chk("R6 early response before beats", 32'(lg_rbeat[0]), 32'd0);
        chk("R6 early response after two pops", 32'(lg_rpop[0]), 32'd2);
        chk("R6 early response clean", 32'(lg_rerr[0]), 32'd0);
        chk("R6 second response after four beats", 32'(lg_rbeat[1]), 32'd4);
    endtask

    task automatic t_err_drop();
        cfg_write(32'h0240_0000);
        run_txn(1'b1, 32'hC000_0000, 4'b0001);
        chk("R7 first response with beat0 error", 32'(lg_rerr[0]), 32'd0);
        chk("R7 beat0 error dropped", 32'(lg_rerr[1]), 32'd0);
        run_txn(1'b1, 32'hC000_0000, 4'b1000);
        chk("R7 beat3 error reported", 32'(lg_rerr[1]), 32'd1);
    endtask

    task automatic t_err_merge();
        cfg_write(32'h0260_0000);
        run_txn(1'b1, 32'hC000_0000, 4'b0010);
        chk("R8 early response still clean", 32'(lg_rerr[0]), 32'd0);
        chk("R8 beat1 error merged", 32'(lg_rerr[1]), 32'd1);
        run_txn(1'b1, 32'hC000_0000, 4'b0000);
        chk("R9 no leak into next burst", 32'(lg_rerr[1]), 32'd0);
    endtask

    task automatic t_single_errs();
        cfg_write(32'h0020_0000);
        run_txn(1'b1, 32'h0000_0020, 4'b0010);
        chk_beats("R11 single write", 32'h0000_0020, 1'b0);
        chk("R11 single write first response after two beats", 32'(lg_rbeat[0]), 32'd2);
        chk("R11 single write first half error", 32'(lg_rerr[0]), 32'd1);
        chk("R11 single write second half clean", 32'(lg_rerr[1]), 32'd0);
        for (int i = 0; i < 4; i++)
            chk("R12 single write data order", lg_wdata[i], 32'hD000_0000 + 32'(i));
        run_txn(1'b0, 32'h0000_0020, 4'b0100);
        chk("R11 read first half clean", 32'(lg_rerr[0]), 32'd0);
        chk("R11 read second half error", 32'(lg_rerr[1]), 32'd1);
    endtask

    task automatic t_latched();
        cfg_write(32'h8080_0000);
        slow = 1'b1;
        start_txn(1'b0, 32'h0000_0200, 4'b0000);
        cfg_write(32'h0);
        wait_txn();
        chk_beats("R10 decision latched (stalling slave)", 32'h0000_0200, 1'b1);
        run_txn(1'b0, 32'h0000_0200, 4'b0000);
        chk_beats("R10 new setting on next txn", 32'h0000_0200, 1'b0);
        slow = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_layout();
        t_read_modes();
        t_write_modes();
        t_err_drop();
        t_err_merge();
        t_single_errs();
        t_latched();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule